// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a logical address, made of a 16-bit segment selector and an offset, into a linear address. It serves a set of segment registers. A segment register is loaded with a selector, and translation requests later name that register by index. The block works in one of two modes, chosen by a level input. In real mode a load only records the selector. A translation then shifts the selector left by four bits and adds the low 16 bits of the offset, giving a 20-bit result.

In protected mode, loading a selector starts a fetch of a 64-bit descriptor through a plain read port, as two 32-bit reads. Selector bit 2 picks one of two table base inputs, and selector bits 15:3 give the entry index. The descriptor's base, limit, granularity, code flag, writable flag and privilege level are kept in a hidden cache entry for that segment register. A translation adds the cached base to the full 32-bit offset. It checks the offset against the limit, scaled by the granularity, and checks the write permission. A violation raises a fault and forces the address output to zero. While a fetch is running, a busy output tells requesters that new loads and translations are not taken.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, busy_o, mem_req_o, xl_done_o and xl_fault_o are all 0.
- R2: With prot_mode_i=0, a load writes the selector into the named segment register in the clock edge that takes it. It issues no memory read, and busy_o stays 0. A translation returns ((selector*16 + xl_off_i[15:0]) mod 2^20), zero-extended to 32 bits. Offset bits 31:16 are ignored, the fault output is 0 for an in-range register, and writes are allowed.
- R3: With prot_mode_i=1, a load reads at table base + selector[15:3]*8. The table base is gdt_base_i when selector bit 2 is 0 and ldt_base_i when it is 1. The first read is at that address and the second at that address plus 4. busy_o is high from the cycle after the load is taken until the second read is acknowledged. A read is complete in a cycle where mem_req_o and mem_ack_i are both high, and mem_rdata_i is taken in that cycle.
- R4: Descriptor layout. The first word read is the 32-bit base. In the second word, bits 19:0 are the limit, bit 20 is granularity (1 selects 4 KB units), bit 21 is the code flag, bit 22 is the writable flag, and bits 24:23 are the privilege level.
- R5: A protected-mode translation that is taken (xl_valid_i=1 with busy_o=0) gives xl_done_o=1 in the next cycle. In that cycle xl_lin_o = (base + offset) mod 2^32, and xl_dpl_o shows the cached privilege level.
- R6: With byte granularity, an offset greater than the limit faults, and an offset equal to the limit does not.
- R7: With 4 KB granularity, the effective limit is limit*4096 + 4095.
- R8: A write (xl_write_i=1) to a segment whose code flag is 1 or whose writable flag is 0 faults, and a read from the same segment does not.
- R9: When xl_fault_o is 1, xl_lin_o and xl_dpl_o are 0.
- R10: Loads and translations presented while busy_o is 1 are ignored. No xl_done_o follows, and no further fetch is made.
- R11: Two cases fault in protected mode: a segment register not loaded in protected mode (including one last loaded in real mode), and a register index of NSEG or above. A register index of NSEG or above also faults in real mode.
- R12: Loading one segment register leaves the cached contents of every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode_i | input | 1 | 1 selects protected mode, 0 selects real mode |
| gdt_base_i | input | 32 | Base address of the global table |
| ldt_base_i | input | 32 | Base address of the local table |
| ld_valid_i | input | 1 | Load a selector into a segment register |
| ld_seg_i | input | SEGW | Segment register index for the load |
| ld_sel_i | input | 16 | Selector to load |
| busy_o | output | 1 | Descriptor fetch in progress |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| xl_valid_i | input | 1 | Translation request |
| xl_seg_i | input | SEGW | Segment register index for the translation |
| xl_off_i | input | 32 | Offset |
| xl_write_i | input | 1 | 1 for a write access |
| xl_done_o | output | 1 | Translation result valid |
| xl_lin_o | output | 32 | Linear address, 0 on fault |
| xl_fault_o | output | 1 | Limit, permission or validity fault |
| xl_dpl_o | output | 2 | Privilege level of the segment, 0 on fault |

## Verification
The bench builds the block with NSEG=6, so SEGW=3. Indices 6 and 7 can then be driven on the ports and exercise the out-of-range fault path. It places descriptors in both tables, including one whose base wraps past 2^32, one with 4 KB granularity, and a code segment. This puts the exact limit boundary in both granularities within reach, along with wrap of the 20-bit and 32-bit sums. A memory model with one idle cycle before each acknowledge stretches the fetch. This leaves room to drive loads and translations while busy_o is high.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int ADDR_W   = 32;
  localparam int SEL_W    = 16;
  localparam int LIM_W    = 20;
  localparam int PAGE_SH  = 12;
  localparam int REAL_W   = 20;
  localparam int REAL_SH  = 4;
  localparam int DESC_SH  = 3;
  localparam int TI_BIT   = 2;
  localparam int GRAN_BIT = 20;
  localparam int CODE_BIT = 21;
  localparam int WR_BIT   = 22;
  localparam int DPL_LSB  = 23;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              code;
    logic              wr;
    logic [1:0]        dpl;
    logic              valid;
  } seg_desc_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2
  } fetch_st_e;

  function automatic seg_desc_t desc_unpack(input logic [31:0] w0,
                                            input logic [31:0] w1);
    seg_desc_t d;
    d.base  = w0;
    d.limit = w1[LIM_W-1:0];
    d.gran  = w1[GRAN_BIT];
    d.code  = w1[CODE_BIT];
    d.wr    = w1[WR_BIT];
    d.dpl   = w1[DPL_LSB+:2];
    d.valid = 1'b1;
    return d;
  endfunction

endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int SEGW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [SEGW-1:0]         seg_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [ADDR_W-1:0]       gdt_base_i,
  input  logic [ADDR_W-1:0]       ldt_base_i,
  output logic                    busy_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_ack_i,
  input  logic [31:0]             mem_rdata_i,
  output logic                    wr_en_o,
  output logic [SEGW-1:0]         wr_seg_o,
  output seg_desc_t               wr_desc_o
);

  localparam int IDX_W = SEL_W - DESC_SH;

  fetch_st_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [31:0]       lo_q, lo_d;
  logic [SEGW-1:0]   seg_q, seg_d;
  logic              addr_en, lo_en, seg_en;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] idx_off;
  logic [1:0]        unused_rpl;

  assign unused_rpl = sel_i[1:0];
  assign tbl_base   = sel_i[TI_BIT] ? ldt_base_i : gdt_base_i;
  assign idx_off    = {{(ADDR_W-SEL_W){1'b0}}, sel_i[SEL_W-1:DESC_SH], {DESC_SH{1'b0}}};

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    lo_d    = lo_q;
    seg_d   = seg_q;
    addr_en = 1'b0;
    lo_en   = 1'b0;
    seg_en  = 1'b0;
    wr_en_o = 1'b0;
    case (state_q)
      FS_IDLE: begin
        if (start_i) begin
          addr_d  = tbl_base + idx_off;
          addr_en = 1'b1;
          seg_d   = seg_i;
          seg_en  = 1'b1;
          state_d = FS_LO;
        end
      end
      FS_LO: begin
        if (mem_ack_i) begin
          lo_d    = mem_rdata_i;
          lo_en   = 1'b1;
          addr_d  = addr_q + ADDR_W'(4);
          addr_en = 1'b1;
          state_d = FS_HI;
        end
      end
      FS_HI: begin
        if (mem_ack_i) begin
          wr_en_o = 1'b1;
          state_d = FS_IDLE;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
      seg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
      if (lo_en)   lo_q   <= lo_d;
      if (seg_en)  seg_q  <= seg_d;
    end
  end

  assign busy_o     = (state_q != FS_IDLE);
  assign mem_req_o  = (state_q == FS_LO) || (state_q == FS_HI);
  assign mem_addr_o = addr_q;
  assign wr_seg_o   = seg_q;
  assign wr_desc_o  = desc_unpack(lo_q, mem_rdata_i);

endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int SEGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [SEGW-1:0] wr_seg_i,
  input  seg_desc_t       wr_desc_i,
  input  logic [SEGW-1:0] rd_seg_i,
  output seg_desc_t       rd_desc_o,
  output logic            rd_hit_o
);

  seg_desc_t ent_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en_i && (wr_seg_i == SEGW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (ent_en) begin
        ent_q[g] <= wr_desc_i;
      end
    end
  end

  always_comb begin
    rd_desc_o = '0;
    rd_hit_o  = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_seg_i == SEGW'(i)) begin
        rd_desc_o = ent_q[i];
        rd_hit_o  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_calc.sv
module seg_xlate_calc
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              prot_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] off_i,
  input  seg_desc_t         desc_i,
  input  logic              hit_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] lin_o,
  output logic              fault_o,
  output logic [1:0]        dpl_o
);

  logic [ADDR_W-1:0] span;
  logic [REAL_W-1:0] real_sum;
  logic [ADDR_W-1:0] prot_sum;
  logic              lim_bad, perm_bad, flt;
  logic [ADDR_W-1:0] lin_d;
  logic [1:0]        dpl_d;
  logic              done_q;
  logic [ADDR_W-1:0] lin_q;
  logic              fault_q;
  logic [1:0]        dpl_q;

  assign span     = desc_i.gran ? {desc_i.limit, {PAGE_SH{1'b1}}}
                                : {{(ADDR_W-LIM_W){1'b0}}, desc_i.limit};
  assign real_sum = desc_i.base[REAL_W-1:0] + {{(REAL_W-16){1'b0}}, off_i[15:0]};
  assign prot_sum = desc_i.base + off_i;
  assign lim_bad  = off_i > span;
  assign perm_bad = write_i && (desc_i.code || !desc_i.wr);

  always_comb begin
    if (!prot_i) begin
      flt   = !hit_i;
      lin_d = {{(ADDR_W-REAL_W){1'b0}}, real_sum};
      dpl_d = 2'd0;
    end else begin
      flt   = !hit_i || !desc_i.valid || lim_bad || perm_bad;
      lin_d = prot_sum;
      dpl_d = desc_i.dpl;
    end
    if (flt) begin
      lin_d = '0;
      dpl_d = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      lin_q   <= '0;
      dpl_q   <= '0;
    end else begin
      done_q  <= req_i;
      fault_q <= req_i && flt;
      if (req_i) begin
        lin_q <= lin_d;
        dpl_q <= dpl_d;
      end
    end
  end

  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign lin_o   = lin_q;
  assign dpl_o   = dpl_q;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter  int NSEG = 6,
  localparam int SEGW = (NSEG > 1) ? $clog2(NSEG + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode_i,
  input  logic [31:0]       gdt_base_i,
  input  logic [31:0]       ldt_base_i,
  input  logic              ld_valid_i,
  input  logic [SEGW-1:0]   ld_seg_i,
  input  logic [15:0]       ld_sel_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              xl_valid_i,
  input  logic [SEGW-1:0]   xl_seg_i,
  input  logic [31:0]       xl_off_i,
  input  logic              xl_write_i,
  output logic              xl_done_o,
  output logic [31:0]       xl_lin_o,
  output logic              xl_fault_o,
  output logic [1:0]        xl_dpl_o
);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic      ld_hit;
  logic      fetch_start;
  logic      real_wr;
  logic      fetch_wr;
  logic [SEGW-1:0] fetch_seg;
  seg_desc_t fetch_desc;
  seg_desc_t real_desc;
  logic      cache_wr;
  logic [SEGW-1:0] cache_seg;
  seg_desc_t cache_wdesc;
  seg_desc_t rd_desc;
  logic      rd_hit;
  logic      xl_take;

  assign ld_hit      = ({1'b0, ld_seg_i} < (SEGW+1)'(NSEG));
  assign fetch_start = ld_valid_i && prot_mode_i && !busy_o && ld_hit;
  assign real_wr     = ld_valid_i && !prot_mode_i && !busy_o;
  assign xl_take     = xl_valid_i && !busy_o;

  always_comb begin
    real_desc       = '0;
    real_desc.base  = {{(ADDR_W-SEL_W-REAL_SH){1'b0}}, ld_sel_i, {REAL_SH{1'b0}}};
    real_desc.limit = LIM_W'(20'h0FFFF);
    real_desc.wr    = 1'b1;
  end

  always_comb begin
    if (fetch_wr) begin
      cache_wr    = 1'b1;
      cache_seg   = fetch_seg;
      cache_wdesc = fetch_desc;
    end else begin
      cache_wr    = real_wr;
      cache_seg   = ld_seg_i;
      cache_wdesc = real_desc;
    end
  end

  seg_desc_fetch #(.SEGW(SEGW)) i_fetch (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (fetch_start),
    .seg_i      (ld_seg_i),
    .sel_i      (ld_sel_i),
    .gdt_base_i (gdt_base_i),
    .ldt_base_i (ldt_base_i),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .wr_en_o    (fetch_wr),
    .wr_seg_o   (fetch_seg),
    .wr_desc_o  (fetch_desc)
  );

  seg_desc_cache #(.NSEG(NSEG), .SEGW(SEGW)) i_cache (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (cache_wr),
    .wr_seg_i  (cache_seg),
    .wr_desc_i (cache_wdesc),
    .rd_seg_i  (xl_seg_i),
    .rd_desc_o (rd_desc),
    .rd_hit_o  (rd_hit)
  );

  seg_xlate_calc i_calc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (xl_take),
    .prot_i  (prot_mode_i),
    .write_i (xl_write_i),
    .off_i   (xl_off_i),
    .desc_i  (rd_desc),
    .hit_i   (rd_hit),
    .done_o  (xl_done_o),
    .lin_o   (xl_lin_o),
    .fault_o (xl_fault_o),
    .dpl_o   (xl_dpl_o)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter  int NSEG = 6,
  localparam int SEGW = (NSEG > 1) ? $clog2(NSEG + 1) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            prot_mode_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic [31:0]     mem_addr_o,
  input logic            mem_ack_i,
  input logic            xl_valid_i,
  input logic [SEGW-1:0] xl_seg_i,
  input logic            xl_done_o,
  input logic [31:0]     xl_lin_o,
  input logic            xl_fault_o,
  input logic [1:0]      xl_dpl_o
);

  AST_BUSY_BLOCKS_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && xl_valid_i) |=> !xl_done_o); // R10

  AST_FAULT_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault_o |-> (xl_lin_o == 32'd0 && xl_dpl_o == 2'd0)); // R9

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault_o |-> xl_done_o); // R5

  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done_o |-> $past(xl_valid_i && !busy_o)); // R5

  AST_REQ_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R3

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o); // R2

  AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done_o && $past(!prot_mode_i) && ($past(xl_seg_i) < SEGW'(NSEG)))
      |-> !xl_fault_o); // R2

endmodule

bind seg_xlate_unit seg_xlate_chk #(.NSEG(NSEG)) i_seg_xlate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prot_mode_i (prot_mode_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .xl_valid_i  (xl_valid_i),
  .xl_seg_i    (xl_seg_i),
  .xl_done_o   (xl_done_o),
  .xl_lin_o    (xl_lin_o),
  .xl_fault_o  (xl_fault_o),
  .xl_dpl_o    (xl_dpl_o)
);

// File: tb/test_seg_xlate_unit.sv
`timescale 1ns/1ps
module test_seg_xlate_unit;

  localparam int NSEG = 6;
  localparam int SEGW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            prot_mode_i = 1'b0;
  logic [31:0]     gdt_base_i = 32'h0000_0000;
  logic [31:0]     ldt_base_i = 32'h0000_0200;
  logic            ld_valid_i = 1'b0;
  logic [SEGW-1:0] ld_seg_i = '0;
  logic [15:0]     ld_sel_i = '0;
  logic            busy_o, mem_req_o;
  logic [31:0]     mem_addr_o;
  logic            mem_ack_i = 1'b0;
  logic [31:0]     mem_rdata_i = '0;
  logic            xl_valid_i = 1'b0;
  logic [SEGW-1:0] xl_seg_i = '0;
  logic [31:0]     xl_off_i = '0;
  logic            xl_write_i = 1'b0;
  logic            xl_done_o, xl_fault_o;
  logic [31:0]     xl_lin_o;
  logic [1:0]      xl_dpl_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  seg_xlate_unit #(.NSEG(NSEG)) i_seg_xlate_unit (.*);

  logic [31:0] mem [256];
  logic [31:0] log_a [4];
  int          log_n = 0;
  logic        log_clr = 1'b0;

  always @(posedge clk) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= mem[mem_addr_o[9:2]];
    end else begin
      mem_ack_i <= 1'b0;
    end
    if (log_clr) log_n <= 0;
    else if (mem_req_o && mem_ack_i) begin
      if (log_n < 4) log_a[log_n] <= mem_addr_o;
      log_n <= log_n + 1;
    end
  end

  typedef struct packed {
    logic [2:0]  seg;
    logic [31:0] off;
    logic        wr;
    logic        flt;
    logic [31:0] lin;
    logic [1:0]  dpl;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_0000, 1'b0, 1'b0, 32'h0010_0000, 2'd0}, // R5 R12
    '{3'd0, 32'h0000_0FFF, 1'b1, 1'b0, 32'h0010_0FFF, 2'd0}, // R6 edge
    '{3'd0, 32'h0000_1000, 1'b0, 1'b1, 32'h0000_0000, 2'd0}, // R6 R9
    '{3'd1, 32'h0000_3FFF, 1'b0, 1'b0, 32'h4000_3FFF, 2'd3}, // R7 edge
    '{3'd1, 32'h0000_4000, 1'b0, 1'b1, 32'h0000_0000, 2'd0}, // R7
    '{3'd1, 32'h0000_0010, 1'b1, 1'b1, 32'h0000_0000, 2'd0}, // R8 read-only
    '{3'd2, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0000, 2'd2}, // R5 wrap
    '{3'd2, 32'h0000_0020, 1'b1, 1'b1, 32'h0000_0000, 2'd0}, // R8 code
    '{3'd3, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 2'd0}, // R11 unloaded
    '{3'd6, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 2'd0}, // R11 range
    '{3'd1, 32'h0000_0123, 1'b0, 1'b0, 32'h4000_0123, 2'd3}, // R5
    '{3'd5, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 2'd0}  // R11 real-loaded
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_seg(input logic [2:0] seg, input logic [15:0] sel);
    @(negedge clk);
    ld_valid_i = 1'b1;
    ld_seg_i   = seg;
    ld_sel_i   = sel;
    @(negedge clk);
    ld_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 50 && busy_o; n++) @(negedge clk);
  endtask

  task automatic xlate(input logic [2:0] seg, input logic [31:0] off, input logic wr);
    @(negedge clk);
    xl_valid_i = 1'b1;
    xl_seg_i   = seg;
    xl_off_i   = off;
    xl_write_i = wr;
    @(negedge clk);
    xl_valid_i = 1'b0;
    xl_write_i = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[8'h02] = 32'h0010_0000; mem[8'h03] = 32'h0040_0FFF;  // idx1
    mem[8'h04] = 32'h4000_0000; mem[8'h05] = 32'h0190_0003;  // idx2
    mem[8'h06] = 32'h0000_1234; mem[8'h07] = 32'h00C0_000F;  // idx3
    mem[8'h8A] = 32'hFFFF_F000; mem[8'h8B] = 32'h013F_FFFF;  // local idx5

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 req", mem_req_o, 0);
    check("R1 done", xl_done_o, 0);
    check("R1 fault", xl_fault_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 real mode
    load_seg(3'd0, 16'hA1F0);
    check("R2 no busy", busy_o, 0);
    check("R2 no read", mem_req_o, 0);
    xlate(3'd0, 32'h0000_04C0, 1'b0);
    check("R2 done", xl_done_o, 1);
    check("R2 lin", xl_lin_o, 32'h000A_23C0);
    check("R2 fault", xl_fault_o, 0);
    xlate(3'd0, 32'hFFFF_04C0, 1'b1);
    check("R2 upper offset ignored", xl_lin_o, 32'h000A_23C0);
    check("R2 write allowed", xl_fault_o, 0);
    load_seg(3'd1, 16'hFFFF);
    xlate(3'd1, 32'h0000_0010, 1'b0);
    check("R2 20-bit wrap", xl_lin_o, 32'h0000_0000);
    load_seg(3'd5, 16'h1234);
    xlate(3'd7, 32'h0, 1'b0);
    check("R11 real range fault", xl_fault_o, 1);

    // R3 R4 protected loads
    prot_mode_i = 1'b1;
    clear_log();
    load_seg(3'd0, 16'h0008);
    check("R3 busy after load", busy_o, 1);
    check("R3 first addr", mem_addr_o, 32'h0000_0008);
    wait_idle();
    check("R3 busy cleared", busy_o, 0);
    check("R3 second addr", log_a[1], 32'h0000_000C);
    load_seg(3'd1, 16'h0010);
    wait_idle();
    clear_log();
    load_seg(3'd2, 16'h002C);
    wait_idle();
    check("R3 local first addr", log_a[0], 32'h0000_0228);
    check("R3 local second addr", log_a[1], 32'h0000_022C);
    check("R3 read count", log_n, 2);

    // R10 busy hold-off
    clear_log();
    load_seg(3'd4, 16'h0018);
    xl_valid_i = 1'b1; xl_seg_i = 3'd0; xl_off_i = 32'h0;
    ld_valid_i = 1'b1; ld_seg_i = 3'd4; ld_sel_i = 16'h0010;
    @(negedge clk);
    xl_valid_i = 1'b0; ld_valid_i = 1'b0;
    check("R10 no done while busy", xl_done_o, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R10 no extra fetch", log_n, 2);
    xlate(3'd4, 32'h0, 1'b0);
    check("R10 first load kept", xl_lin_o, 32'h0000_1234);
    check("R4 dpl field", xl_dpl_o, 2'd1);

    // Vector table: R4 R5 R6 R7 R8 R9 R11 R12
    for (int v = 0; v < NV; v++) begin
      xlate(VECS[v].seg, VECS[v].off, VECS[v].wr);
      check($sformatf("R5 done v%0d", v), xl_done_o, 1);
      check($sformatf("R9 R6 R7 R8 R11 fault v%0d", v), xl_fault_o, VECS[v].flt);
      check($sformatf("R5 R12 lin v%0d", v), xl_lin_o, VECS[v].lin);
      check($sformatf("R4 dpl v%0d", v), xl_dpl_o, VECS[v].dpl);
    end

    @(negedge clk);
    check("R5 done clears", xl_done_o, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule